// File: doc/BRIEF.md
# Chunked Image Staging Sequencer

This block feeds a firmware image to a staging device in pieces. A run starts with a start pulse and an image length. The block first resets the device with one write to the control register of a small mailbox, four 32-bit registers in size. It then loops until the run ends.

Each pass of the loop does three things in order. It works out the next chunk from the current offset. It hands that chunk (offset and length) to an external data mover through a request/done handshake. It then asks, through a second handshake, which offset the device wants next. The device may ask again for data it has already received. Those repeats are accepted, but the total number of bytes sent may never exceed twice the image length.

A run ends in one of four ways: the device returns the completion marker, the byte budget would be overrun, the send step fails, or the offset fetch fails. The end is reported by a one-cycle done pulse that carries a two-bit result code.

Top module: `stage_seq`

## Requirements
- R1: When a start pulse is accepted in idle, the block latches `img_len_i`. In the next cycle it performs exactly one mailbox write, to byte offset 0x0 with data 0x00000001 (abort bit 0). No read or status check follows, and no other mailbox write occurs during the run.
- R2: The first chunk starts at offset 0. Every chunk has length min(4096, image length − chunk offset), so only a chunk that reaches the end of the image can be shorter than 4096 bytes.
- R3: Each pass runs in a fixed order: one chunk request, then one offset request after the chunk completes successfully. The next chunk starts at the offset the device returned. The two requests are never active together.
- R4: Before each chunk request, the block checks whether bytes sent so far plus the new chunk length exceed twice the image length. If they do, it ends with code 1 (budget) and issues no request. A total exactly equal to twice the length is allowed. Re-sent chunks count toward the total.
- R5: A returned offset of 0xFFFFFFFF ends the run with code 0 (success).
- R6: A chunk completion with its error flag set ends the run with code 2 (send failure), and no offset request follows.
- R7: An offset completion with its error flag set, or a returned offset at or above the image length that is not 0xFFFFFFFF, ends the run with code 3 (fetch failure).
- R8: `done_o` is high for exactly one cycle, with `err_o` valid in that cycle. The block then returns to idle and accepts a new start.
- R9: A start pulse that arrives while a run is in progress is ignored. The latched length and the run's behaviour do not change.
- R10: A chunk or offset request stays high with stable offset and length until its done input is seen high at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only in idle |
| img_len_i | input | 32 | Image length in bytes, latched on start |
| mbx_wr_o | output | 1 | Mailbox write strobe |
| mbx_addr_o | output | 4 | Mailbox write byte offset |
| mbx_wdata_o | output | 32 | Mailbox write data |
| chunk_req_o | output | 1 | Chunk transfer request |
| chunk_off_o | output | 32 | Offset of requested chunk |
| chunk_len_o | output | 13 | Length of requested chunk |
| chunk_done_i | input | 1 | Chunk transfer finished |
| chunk_err_i | input | 1 | Chunk transfer failed (valid with done) |
| off_req_o | output | 1 | Next-offset fetch request |
| off_done_i | input | 1 | Offset fetch finished |
| off_err_i | input | 1 | Offset fetch failed (valid with done) |
| off_val_i | input | 32 | Returned next offset (valid with done) |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 2 | Result: 0 ok, 1 budget, 2 send, 3 fetch |

## Verification
The hardest case to reach from the ports is the budget limit. It is reached only after the device has asked for enough repeated data that the running total sits near twice the image length. The bench plays the device side and returns scripted offsets. One script asks for offset 0 again and again on a one-page image. Its total first lands exactly on the limit, which is still allowed, and the following request must end the run with the budget code and no extra chunk. The bench also delays its done responses by varying amounts, so that held requests are checked as well.

// File: rtl/stage_pkg.sv
package stage_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ABORT,
        ST_CHECK,
        ST_SEND,
        ST_FETCH,
        ST_FINISH
    } stage_state_e;

    typedef enum logic [1:0] {
        RES_OK     = 2'd0,
        RES_BUDGET = 2'd1,
        RES_SEND   = 2'd2,
        RES_FETCH  = 2'd3
    } stage_result_e;

    typedef enum logic [1:0] {
        RK_NEXT,
        RK_COMPLETE,
        RK_FAIL
    } resp_kind_e;

    function automatic int unsigned chunk_width(input int unsigned page_bytes);
        return $clog2(page_bytes) + 1;
    endfunction

endpackage

// File: rtl/stage_chunk_plan.sv
module stage_chunk_plan
    import stage_pkg::*;
#(
    parameter int unsigned LEN_W      = 32,
    parameter int unsigned PAGE_BYTES = 4096,
    parameter int unsigned CL_W       = 13,
    parameter int unsigned BUD_W      = 34
) (
    input  logic [LEN_W-1:0] img_len,
    input  logic [LEN_W-1:0] cur_off,
    input  logic [BUD_W-1:0] sent,
    output logic [CL_W-1:0]  chunk_len,
    output logic             over_budget
);
    localparam logic [LEN_W-1:0] PAGE_L = LEN_W'(PAGE_BYTES);

    logic [LEN_W-1:0] remaining;
    logic [BUD_W-1:0] limit;
    logic [BUD_W-1:0] next_total;

    always_comb begin
        remaining = img_len - cur_off;
        if (remaining < PAGE_L) begin
            chunk_len = remaining[CL_W-1:0];
        end else begin
            chunk_len = CL_W'(PAGE_BYTES);
        end
        limit       = BUD_W'({img_len, 1'b0});
        next_total  = sent + BUD_W'(chunk_len);
        over_budget = (next_total > limit);
    end
endmodule

// File: rtl/stage_resp_eval.sv
module stage_resp_eval
    import stage_pkg::*;
#(
    parameter int unsigned LEN_W = 32
) (
    input  logic [LEN_W-1:0] off_val,
    input  logic             off_err,
    input  logic [LEN_W-1:0] img_len,
    output resp_kind_e       kind
);
    localparam logic [LEN_W-1:0] MARKER = '1;

    always_comb begin
        if (off_err) begin
            kind = RK_FAIL;
        end else if (off_val == MARKER) begin
            kind = RK_COMPLETE;
        end else if (off_val >= img_len) begin
            kind = RK_FAIL;
        end else begin
            kind = RK_NEXT;
        end
    end
endmodule

// File: rtl/stage_mbox_port.sv
module stage_mbox_port #(
    parameter int unsigned MBX_AW    = 4,
    parameter int unsigned MBX_DW    = 32,
    parameter int unsigned CTRL_OFF  = 0,
    parameter int unsigned ABORT_BIT = 0
) (
    input  logic              fire,
    output logic              wr,
    output logic [MBX_AW-1:0] addr,
    output logic [MBX_DW-1:0] wdata
);
    assign wr   = fire;
    assign addr = fire ? MBX_AW'(CTRL_OFF) : '0;

    for (genvar i = 0; i < MBX_DW; i++) begin : g_word
        if (i == ABORT_BIT) begin : g_abort
            assign wdata[i] = fire;
        end else begin : g_zero
            assign wdata[i] = 1'b0;
        end
    end
endmodule

// File: rtl/stage_seq.sv
module stage_seq
    import stage_pkg::*;
#(
    parameter int unsigned LEN_W      = 32,
    parameter int unsigned PAGE_BYTES = 4096,
    parameter int unsigned MBX_AW     = 4,
    parameter int unsigned MBX_DW     = 32,
    parameter int unsigned CTRL_OFF   = 0,
    parameter int unsigned ABORT_BIT  = 0,
    parameter int unsigned CL_W       = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  img_len_i,
    output logic              mbx_wr_o,
    output logic [MBX_AW-1:0] mbx_addr_o,
    output logic [MBX_DW-1:0] mbx_wdata_o,
    output logic              chunk_req_o,
    output logic [LEN_W-1:0]  chunk_off_o,
    output logic [CL_W-1:0]   chunk_len_o,
    input  logic              chunk_done_i,
    input  logic              chunk_err_i,
    output logic              off_req_o,
    input  logic              off_done_i,
    input  logic              off_err_i,
    input  logic [LEN_W-1:0]  off_val_i,
    output logic              done_o,
    output logic [1:0]        err_o
);
    localparam int unsigned BUD_W = LEN_W + 2;

    stage_state_e     state_q;
    stage_result_e    res_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] off_q;
    logic [BUD_W-1:0] sent_q;
    logic [CL_W-1:0]  clen_q;

    logic [CL_W-1:0]  plan_len;
    logic             plan_over;
    resp_kind_e       rkind;

    stage_chunk_plan #(
        .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES), .CL_W(CL_W), .BUD_W(BUD_W)
    ) u_plan (
        .img_len    (len_q),
        .cur_off    (off_q),
        .sent       (sent_q),
        .chunk_len  (plan_len),
        .over_budget(plan_over)
    );

    stage_resp_eval #(.LEN_W(LEN_W)) u_resp (
        .off_val(off_val_i),
        .off_err(off_err_i),
        .img_len(len_q),
        .kind   (rkind)
    );

    stage_mbox_port #(
        .MBX_AW(MBX_AW), .MBX_DW(MBX_DW), .CTRL_OFF(CTRL_OFF), .ABORT_BIT(ABORT_BIT)
    ) u_mbox (
        .fire (state_q == ST_ABORT),
        .wr   (mbx_wr_o),
        .addr (mbx_addr_o),
        .wdata(mbx_wdata_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            res_q   <= RES_OK;
            len_q   <= '0;
            off_q   <= '0;
            sent_q  <= '0;
            clen_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        len_q   <= img_len_i;
                        off_q   <= '0;
                        sent_q  <= '0;
                        state_q <= ST_ABORT;
                    end
                end
                ST_ABORT: begin
                    state_q <= ST_CHECK;
                end
                ST_CHECK: begin
                    if (plan_over) begin
                        res_q   <= RES_BUDGET;
                        state_q <= ST_FINISH;
                    end else begin
                        clen_q  <= plan_len;
                        state_q <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (chunk_done_i) begin
                        if (chunk_err_i) begin
                            res_q   <= RES_SEND;
                            state_q <= ST_FINISH;
                        end else begin
                            sent_q  <= sent_q + BUD_W'(clen_q);
                            state_q <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: begin
                    if (off_done_i) begin
                        unique case (rkind)
                            RK_COMPLETE: begin
                                res_q   <= RES_OK;
                                state_q <= ST_FINISH;
                            end
                            RK_NEXT: begin
                                off_q   <= off_val_i;
                                state_q <= ST_CHECK;
                            end
                            default: begin
                                res_q   <= RES_FETCH;
                                state_q <= ST_FINISH;
                            end
                        endcase
                    end
                end
                ST_FINISH: begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign chunk_req_o = (state_q == ST_SEND);
    assign chunk_off_o = off_q;
    assign chunk_len_o = clen_q;
    assign off_req_o   = (state_q == ST_FETCH);
    assign done_o      = (state_q == ST_FINISH);
    assign err_o       = res_q;
endmodule

// File: rtl/stage_seq_chk.sv
module stage_seq_chk #(
    parameter int unsigned LEN_W      = 32,
    parameter int unsigned PAGE_BYTES = 4096,
    parameter int unsigned MBX_AW     = 4,
    parameter int unsigned MBX_DW     = 32,
    parameter int unsigned CTRL_OFF   = 0,
    parameter int unsigned ABORT_BIT  = 0,
    parameter int unsigned CL_W       = 13,
    parameter int unsigned BUD_W      = 34
) (
    input logic              clk,
    input logic              rst,
    input logic              mbx_wr_o,
    input logic [MBX_AW-1:0] mbx_addr_o,
    input logic [MBX_DW-1:0] mbx_wdata_o,
    input logic              chunk_req_o,
    input logic [LEN_W-1:0]  chunk_off_o,
    input logic [CL_W-1:0]   chunk_len_o,
    input logic              chunk_done_i,
    input logic              chunk_err_i,
    input logic              off_req_o,
    input logic              off_done_i,
    input logic              done_o,
    input logic [1:0]        err_o,
    input logic [LEN_W-1:0]  len_q,
    input logic [BUD_W-1:0]  sent_q
);
    localparam logic [MBX_DW-1:0] ABORT_WORD = MBX_DW'(1) << ABORT_BIT;

    logic [BUD_W-1:0] end_pos;
    logic [BUD_W-1:0] twice_len;
    assign end_pos   = BUD_W'(chunk_off_o) + BUD_W'(chunk_len_o);
    assign twice_len = BUD_W'({len_q, 1'b0});

    assert_abort_word_R1: assert property (@(posedge clk) disable iff (rst)
        mbx_wr_o |-> (mbx_addr_o == MBX_AW'(CTRL_OFF)) && (mbx_wdata_o == ABORT_WORD));

    assert_chunk_shape_R2: assert property (@(posedge clk) disable iff (rst)
        chunk_req_o |-> (chunk_len_o != '0) && (chunk_len_o <= CL_W'(PAGE_BYTES))
                        && (end_pos <= BUD_W'(len_q)));

    assert_req_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        !(chunk_req_o && off_req_o));

    assert_within_budget_R4: assert property (@(posedge clk) disable iff (rst)
        chunk_req_o |-> (sent_q + BUD_W'(chunk_len_o)) <= twice_len);

    assert_send_fail_ends_R6: assert property (@(posedge clk) disable iff (rst)
        (chunk_req_o && chunk_done_i && chunk_err_i) |=> done_o && (err_o == 2'd2) && !off_req_o);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_chunk_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (chunk_req_o && !chunk_done_i) |=> chunk_req_o && $stable(chunk_off_o) && $stable(chunk_len_o));

    assert_off_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (off_req_o && !off_done_i) |=> off_req_o);
endmodule

bind stage_seq stage_seq_chk #(
    .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES), .MBX_AW(MBX_AW), .MBX_DW(MBX_DW),
    .CTRL_OFF(CTRL_OFF), .ABORT_BIT(ABORT_BIT), .CL_W(CL_W), .BUD_W(LEN_W + 2)
) u_chk (
    .clk(clk), .rst(rst),
    .mbx_wr_o(mbx_wr_o), .mbx_addr_o(mbx_addr_o), .mbx_wdata_o(mbx_wdata_o),
    .chunk_req_o(chunk_req_o), .chunk_off_o(chunk_off_o), .chunk_len_o(chunk_len_o),
    .chunk_done_i(chunk_done_i), .chunk_err_i(chunk_err_i),
    .off_req_o(off_req_o), .off_done_i(off_done_i),
    .done_o(done_o), .err_o(err_o),
    .len_q(len_q), .sent_q(sent_q)
);

// File: tb/tb_stage_seq.sv
module tb_stage_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [31:0] img_len_i;
    logic        mbx_wr_o;
    logic [3:0]  mbx_addr_o;
    logic [31:0] mbx_wdata_o;
    logic        chunk_req_o;
    logic [31:0] chunk_off_o;
    logic [12:0] chunk_len_o;
    logic        chunk_done_i;
    logic        chunk_err_i;
    logic        off_req_o;
    logic        off_done_i;
    logic        off_err_i;
    logic [31:0] off_val_i;
    logic        done_o;
    logic [1:0]  err_o;

    always #5 clk = ~clk;

    stage_seq dut (
        .clk(clk), .rst(rst), .start_i(start_i), .img_len_i(img_len_i),
        .mbx_wr_o(mbx_wr_o), .mbx_addr_o(mbx_addr_o), .mbx_wdata_o(mbx_wdata_o),
        .chunk_req_o(chunk_req_o), .chunk_off_o(chunk_off_o), .chunk_len_o(chunk_len_o),
        .chunk_done_i(chunk_done_i), .chunk_err_i(chunk_err_i),
        .off_req_o(off_req_o), .off_done_i(off_done_i), .off_err_i(off_err_i),
        .off_val_i(off_val_i), .done_o(done_o), .err_o(err_o)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int unsigned rsp_val [16];
    bit          rsp_err [16];
    int          n_rsp;
    int          send_fail_at;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic string res_req(input int code);
        case (code)
            0: return "R5";
            1: return "R4";
            2: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Plays the device side, predicts every chunk and the final result.
    task automatic run(input int unsigned len, input bit busy_start, input string name);
        longint m_off = 0;
        longint m_sent = 0;
        int     m_res = -1;
        int     k = 0;
        int     c = 0;
        int     wait_cnt = 0;
        int     writes = 0;
        bit     ended = 0;
        @(negedge clk);
        start_i   = 1'b1;
        img_len_i = len;
        @(negedge clk);
        start_i = 1'b0;
        chk(mbx_wr_o == 1'b1, "R1", {name, " abort write strobe"}, mbx_wr_o, 1);
        chk(mbx_addr_o == 4'h0, "R1", {name, " abort write offset"}, mbx_addr_o, 0);
        chk(mbx_wdata_o == 32'h1, "R1", {name, " abort write data"}, mbx_wdata_o, 1);
        writes = 1;
        for (int cyc = 0; cyc < 4000 && !ended; cyc++) begin
            @(negedge clk);
            chunk_done_i = 1'b0;
            chunk_err_i  = 1'b0;
            off_done_i   = 1'b0;
            off_err_i    = 1'b0;
            start_i      = 1'b0;
            if (busy_start && cyc == 6) begin
                start_i   = 1'b1;
                img_len_i = len + 5000;
            end
            if (mbx_wr_o) writes++;
            if (chunk_req_o) begin
                if (wait_cnt < c % 3) begin
                    wait_cnt++;
                end else begin
                    longint exp_len = (len - m_off < 4096) ? len - m_off : 4096;
                    wait_cnt = 0;
                    chk(m_res == -1 && m_sent + exp_len <= 2 * longint'(len), "R4",
                        {name, " chunk issued when none allowed"}, c, -1);
                    chk(chunk_off_o == m_off, "R3", {name, " chunk offset"}, chunk_off_o, m_off);
                    chk(chunk_len_o == exp_len, "R2", {name, " chunk length"}, chunk_len_o, exp_len);
                    chunk_done_i = 1'b1;
                    chunk_err_i  = (c == send_fail_at);
                    if (c == send_fail_at) m_res = 2;
                    else m_sent += exp_len;
                    c++;
                end
            end
            if (off_req_o) begin
                if (wait_cnt < k % 2) begin
                    wait_cnt++;
                end else begin
                    wait_cnt = 0;
                    chk(k < n_rsp && m_res == -1, "R3", {name, " unexpected offset request"}, k, n_rsp);
                    off_done_i = 1'b1;
                    off_val_i  = (k < n_rsp) ? rsp_val[k] : 32'hFFFF_FFFF;
                    off_err_i  = (k < n_rsp) ? rsp_err[k] : 1'b0;
                    if (off_err_i) m_res = 3;
                    else if (off_val_i == 32'hFFFF_FFFF) m_res = 0;
                    else if (off_val_i >= len) m_res = 3;
                    else begin
                        longint nl;
                        m_off = off_val_i;
                        nl = (len - m_off < 4096) ? len - m_off : 4096;
                        if (m_sent + nl > 2 * longint'(len)) m_res = 1;
                    end
                    k++;
                end
            end
            if (done_o) begin
                ended = 1;
                chk(err_o == m_res, res_req(m_res), {name, " result code"}, err_o, m_res);
                chk(writes == 1, "R9", {name, " single mailbox write per run"}, writes, 1);
            end
        end
        chk(ended, "R8", {name, " run ended"}, ended, 1);
        @(negedge clk);
        chk(done_o == 1'b0 && chunk_req_o == 1'b0 && off_req_o == 1'b0, "R8",
            {name, " done is one cycle and block idles"}, done_o, 0);
        off_val_i = '0;
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(done_o == 0 && chunk_req_o == 0 && off_req_o == 0 && mbx_wr_o == 0, "R8",
            "reset quiet outputs", {done_o, chunk_req_o, off_req_o, mbx_wr_o}, 0);
    endtask

    task automatic test_plain();
        n_rsp = 3; send_fail_at = -1;
        rsp_val[0] = 4096; rsp_val[1] = 8192; rsp_val[2] = 32'hFFFF_FFFF;
        for (int i = 0; i < 16; i++) rsp_err[i] = 0;
        run(10000, 0, "plain");
    endtask

    task automatic test_retransmit();
        n_rsp = 3; send_fail_at = -1;
        rsp_val[0] = 0; rsp_val[1] = 4096; rsp_val[2] = 32'hFFFF_FFFF;
        run(8192, 0, "retransmit");
    endtask

    task automatic test_budget_R4();
        n_rsp = 2; send_fail_at = -1;
        rsp_val[0] = 0; rsp_val[1] = 0;
        run(4096, 0, "budget");
    endtask

    task automatic test_send_fail();
        n_rsp = 1; send_fail_at = 1;
        rsp_val[0] = 4096;
        run(10000, 0, "send_fail");
    endtask

    task automatic test_fetch_flag();
        n_rsp = 1; send_fail_at = -1;
        rsp_val[0] = 4096; rsp_err[0] = 1;
        run(10000, 0, "fetch_flag");
        rsp_err[0] = 0;
    endtask

    task automatic test_fetch_range();
        n_rsp = 1; send_fail_at = -1;
        rsp_val[0] = 10000;
        run(10000, 0, "fetch_range");
    endtask

    task automatic test_short_image();
        n_rsp = 1; send_fail_at = -1;
        rsp_val[0] = 32'hFFFF_FFFF;
        run(100, 0, "short");
    endtask

    task automatic test_busy_start();
        n_rsp = 3; send_fail_at = -1;
        rsp_val[0] = 4096; rsp_val[1] = 8192; rsp_val[2] = 32'hFFFF_FFFF;
        run(10000, 1, "busy_start");
    endtask

    initial begin
        start_i = 0; img_len_i = 0;
        chunk_done_i = 0; chunk_err_i = 0;
        off_done_i = 0; off_err_i = 0; off_val_i = 0;
        test_reset();
        test_plain();
        test_retransmit();
        test_budget_R4();
        test_send_fail();
        test_fetch_flag();
        test_fetch_range();
        test_short_image();
        test_busy_start();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #1500000;
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule